// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words. Each word has a sign bit, an 8-bit exponent with bias 127 and a 23-bit fraction. A request is a one-cycle `in_valid` strobe that carries `op_a`, `op_b` and `sub_sel`. The block then works through a fixed sequence of states. It aligns the operand with the smaller magnitude and adds or subtracts the significands. It then normalizes the sum and rounds it to nearest-even. When rounding carries out of the significand, it goes back to normalize. The result is returned with a one-cycle `res_valid` pulse and two flags, `overflow` and `underflow`.

Special operands are decoded when the request is accepted. An exponent field of 0 means a zero or a denormal, with hidden bit 0. An exponent field of 255 means an infinity or a NaN. These special operands take a short path straight to the output. Only one operation is in flight at a time. A caller issues the next request only after it has seen `res_valid`.

States and transitions:
- IDLE to ALIGN: a request with two finite operands is accepted.
- IDLE to SPECIAL: a request with a NaN or infinite operand is accepted.
- ALIGN to ADD: the operands are swapped if needed and the smaller one is shifted right.
- ADD to NORM: the significands are summed.
- NORM to ROUND: the sum is normalized.
- ROUND to NORM: rounding carried out of the significand.
- ROUND to IDLE: the result is delivered.
- SPECIAL to IDLE: the special result is delivered.

Top module: `fpadd_seq`

## Requirements
- R1: The exponent field is biased by 127. A field from 1 to 254 gives significand 1.fraction. A field of 0 gives significand 0.fraction with a weight of 2^-126. Denormal operands add exactly, so 0x00000003 + 0x00000005 = 0x00000008.
- R2: For two finite operands, the result is the exact sum rounded to nearest with ties to even. For example, 0x3F000000 + 0xBEE00000 = 0x3D800000, and the tie 0x3F800000 + 0x33800000 = 0x3F800000.
- R3: When `sub_sel` is 1, the block computes op_a − op_b by inverting the sign of op_b before alignment. For example, 0x40A00000 − 0x3F000000 = 0x40900000.
- R4: A NaN operand, or two infinities of opposite effective sign, gives the quiet NaN 0x7FC00000 with both flags clear.
- R5: An infinity combined with a finite operand gives that infinity with its effective sign, with both flags clear.
- R6: A normalized biased exponent of 255 or more gives an infinity with the result's sign (0x7F800000 or 0xFF800000) and sets `overflow`. `overflow` and `underflow` are never set together.
- R7: A nonzero result below the normal range is delivered as a denormal (exponent field 0) and sets `underflow`. For example, 0x00800000 − 0x00000001 = 0x007FFFFF.
- R8: An exact zero sum of operands with opposite effective signs gives +0 (0x00000000). The sum −0 + −0 gives 0x80000000.
- R9: If rounding carries out of the significand, the result is normalized again and the exponent goes up by one. For example, 0x3FFFFFFF + 0x33800000 = 0x40000000.
- R10: `res_valid` is a one-cycle pulse. Count rising edges after the edge that accepts the request. It appears after 4 edges for finite operands, after 6 when rounding carries, and after 1 for special operands.
- R11: `in_valid` is ignored while an operation is in flight. Such a strobe changes neither the pending result nor produces a later result.
- R12: After reset, `res_valid`, `overflow` and `underflow` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, taken only when idle |
| sub_sel | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Result word, held until the next result |
| overflow | output | 1 | Result overflowed to infinity |
| underflow | output | 1 | Result is a nonzero denormal |

## Verification
Directed operand pairs separate the datapath's distinct paths:
- the worked mixed-sign sum, which needs a three-place left normalization;
- an exact cancellation, which must give +0;
- a round-to-even tie and a rounding carry, where only the renormalize loop gives the right word and latency;
- the largest finite values, which must overflow;
- a normal minus the smallest denormal, which must underflow.

Random operands are drawn from weighted classes: zeros, denormals, exponents near both ends of the range, infinities and NaNs, and near-equal pairs that cancel. Each is compared against an exact wide-integer sum rounded in the bench. This catches alignment, sticky-bit and sign errors that a handful of directed cases would miss. A strobe sent during a busy operation shows whether requests are queued or ignored.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;

    // Control sequence of the adder
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_ROUND,
        ST_SPECIAL
    } state_t;

    // Operand class flags produced by the unpacker
    typedef struct packed {
        logic is_inf;
        logic is_nan;
    } fclass_t;

endpackage

// File: rtl/fpadd_unpack.sv
`timescale 1ns/1ps
module fpadd_unpack
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  flip,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_eff,
    output logic [FRAC_W:0]       sig,
    output fclass_t               cls
);
    localparam int MSB = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              low_field;

    always_comb begin
        exp_f      = word[MSB-1:FRAC_W];
        frac_f     = word[FRAC_W-1:0];
        low_field  = (exp_f == '0);
        sign       = word[MSB] ^ flip;
        // a zero exponent field weighs like field 1 but has no hidden one
        exp_eff    = low_field ? EXP_W'(1) : exp_f;
        sig        = {~low_field, frac_f};
        cls.is_inf = (&exp_f) && (frac_f == '0);
        cls.is_nan = (&exp_f) && (|frac_f);
    end

endmodule

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
module fpadd_align #(
    parameter int W    = 27,
    parameter int SH_W = 8
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] kept;
    logic [W-1:0] mask;
    logic         lost;

    always_comb begin
        mask = ~({W{1'b1}} << shamt);
        kept = din >> shamt;
        lost = |(din & mask);
        if (shamt >= SH_W'(W)) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            // everything shifted out is folded into the sticky position
            dout = {kept[W-1:1], kept[0] | lost};
        end
    end

endmodule

// File: rtl/fpadd_lzc.sv
`timescale 1ns/1ps
module fpadd_lzc #(
    parameter int W    = 27,
    parameter int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  v,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (v[i]) cnt = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/fpadd_seq.sv
`timescale 1ns/1ps
module fpadd_seq
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  sub_sel,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  res_valid,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  overflow,
    output logic                  underflow
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;          // hidden, fraction, guard, round, sticky
    localparam int SUM_W  = EXT_W + 1;          // plus carry position
    localparam int XE_W   = EXP_W + 1;
    localparam int LZ_W   = $clog2(EXT_W + 1);
    localparam logic [XE_W-1:0]   EXP_TOP = XE_W'((1 << EXP_W) - 1);
    localparam logic [WORD_W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    state_t state, state_nx;

    // ---------------- unpack ----------------
    logic              a_s, b_s;
    logic [EXP_W-1:0]  a_e, b_e;
    logic [FRAC_W:0]   a_m, b_m;
    fclass_t           a_c, b_c;

    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
        .word(op_a), .flip(1'b0), .sign(a_s), .exp_eff(a_e), .sig(a_m), .cls(a_c)
    );
    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
        .word(op_b), .flip(sub_sel), .sign(b_s), .exp_eff(b_e), .sig(b_m), .cls(b_c)
    );

    logic              is_spec;
    logic [WORD_W-1:0] spec_word;

    always_comb begin
        is_spec = a_c.is_nan | a_c.is_inf | b_c.is_nan | b_c.is_inf;
        if (a_c.is_nan || b_c.is_nan)
            spec_word = QNAN;
        else if (a_c.is_inf && b_c.is_inf && (a_s != b_s))
            spec_word = QNAN;
        else if (a_c.is_inf)
            spec_word = {a_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            spec_word = {b_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end

    // ---------------- datapath registers ----------------
    logic              sgn_a, sgn_b, eff_sub;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [EXT_W-1:0]  sig_a, sig_b;
    logic [EXT_W-1:0]  op_x, op_y;
    logic [XE_W-1:0]   exp_r;
    logic              sign_r;
    logic [SUM_W-1:0]  sum_q;
    logic [WORD_W-1:0] spec_q;

    // ---------------- align stage ----------------
    logic              a_big;
    logic [EXP_W-1:0]  big_e, sml_e, diff;
    logic [EXT_W-1:0]  big_m, sml_m, sml_al;
    logic              big_s;

    always_comb begin
        a_big = {exp_a, sig_a} >= {exp_b, sig_b};
        big_e = a_big ? exp_a : exp_b;
        sml_e = a_big ? exp_b : exp_a;
        big_m = a_big ? sig_a : sig_b;
        sml_m = a_big ? sig_b : sig_a;
        big_s = a_big ? sgn_a : sgn_b;
        diff  = big_e - sml_e;
    end

    fpadd_align #(.W(EXT_W), .SH_W(EXP_W)) u_align (
        .din(sml_m), .shamt(diff), .dout(sml_al)
    );

    // ---------------- normalize stage ----------------
    logic [LZ_W-1:0] lz;
    logic [XE_W-1:0] lz_ext, room, sh_l;

    fpadd_lzc #(.W(EXT_W), .CW(LZ_W)) u_lzc (
        .v(sum_q[EXT_W-1:0]), .cnt(lz)
    );

    always_comb begin
        lz_ext = XE_W'(lz);
        room   = exp_r - XE_W'(1);
        // never shift below the smallest exponent: what is left is a denormal
        sh_l   = (lz_ext < room) ? lz_ext : room;
    end

    // ---------------- round stage ----------------
    logic             up;
    logic [SIG_W:0]   rnd;
    logic             rnd_carry;
    logic             fin_ovf, fin_unf;
    logic [WORD_W-1:0] fin_word;

    always_comb begin
        up        = sum_q[2] & (sum_q[1] | sum_q[0] | sum_q[3]);
        rnd       = {1'b0, sum_q[EXT_W-1:3]} + {{SIG_W{1'b0}}, up};
        rnd_carry = rnd[SIG_W];
        fin_ovf   = (exp_r >= EXP_TOP);
        if (fin_ovf)
            fin_word = {sign_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            fin_word = {sign_r, (rnd[FRAC_W] ? exp_r[EXP_W-1:0] : {EXP_W{1'b0}}), rnd[FRAC_W-1:0]};
        fin_unf   = !fin_ovf && !rnd[FRAC_W] && (|rnd[FRAC_W-1:0]);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (in_valid) state_nx = is_spec ? ST_SPECIAL : ST_ALIGN;
            ST_ALIGN:   state_nx = ST_ADD;
            ST_ADD:     state_nx = ST_NORM;
            ST_NORM:    state_nx = ST_ROUND;
            ST_ROUND:   state_nx = rnd_carry ? ST_NORM : ST_IDLE;
            ST_SPECIAL: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // ---------------- datapath sequencing ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgn_a   <= 1'b0;
            sgn_b   <= 1'b0;
            eff_sub <= 1'b0;
            exp_a   <= '0;
            exp_b   <= '0;
            sig_a   <= '0;
            sig_b   <= '0;
            op_x    <= '0;
            op_y    <= '0;
            exp_r   <= '0;
            sign_r  <= 1'b0;
            sum_q   <= '0;
            spec_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        sgn_a   <= a_s;
                        sgn_b   <= b_s;
                        eff_sub <= a_s ^ b_s;
                        exp_a   <= a_e;
                        exp_b   <= b_e;
                        sig_a   <= {a_m, 3'b000};
                        sig_b   <= {b_m, 3'b000};
                        spec_q  <= spec_word;
                    end
                end
                ST_ALIGN: begin
                    op_x   <= big_m;
                    op_y   <= sml_al;
                    exp_r  <= {1'b0, big_e};
                    sign_r <= big_s;
                end
                ST_ADD: begin
                    if (eff_sub) sum_q <= {1'b0, op_x} - {1'b0, op_y};
                    else         sum_q <= {1'b0, op_x} + {1'b0, op_y};
                    if (eff_sub && (op_x == op_y)) sign_r <= 1'b0;
                end
                ST_NORM: begin
                    if (sum_q[EXT_W]) begin
                        sum_q <= {1'b0, sum_q[SUM_W-1:2], sum_q[1] | sum_q[0]};
                        exp_r <= exp_r + XE_W'(1);
                    end else begin
                        sum_q <= sum_q << sh_l;
                        exp_r <= exp_r - sh_l;
                    end
                end
                ST_ROUND: begin
                    if (rnd_carry) sum_q <= {rnd, 3'b000};
                end
                ST_SPECIAL: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (state == ST_ROUND && !rnd_carry) begin
                res_valid <= 1'b1;
                result    <= fin_word;
                overflow  <= fin_ovf;
                underflow <= fin_unf;
            end else if (state == ST_SPECIAL) begin
                res_valid <= 1'b1;
                result    <= spec_q;
                overflow  <= 1'b0;
                underflow <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fpadd_seq_chk.sv
`timescale 1ns/1ps
module fpadd_seq_chk
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  res_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  overflow,
    input logic                  underflow,
    input state_t                state
);
    localparam int MSB = EXP_W + FRAC_W;
    localparam logic [MSB:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // R10: result strobe lasts one cycle
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R10: a strobe only follows a delivering state
    assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> ($past(state) == ST_ROUND || $past(state) == ST_SPECIAL));

    // R6: overflow always reports an infinity
    assert_ovf_is_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (result[MSB-1:FRAC_W] == '1 && result[FRAC_W-1:0] == '0));

    // R6: flags are exclusive
    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

    // R7: underflow always reports a nonzero denormal
    assert_unf_denorm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (result[MSB-1:FRAC_W] == '0 && result[FRAC_W-1:0] != '0));

    // R4: any NaN delivered is the canonical quiet one
    assert_nan_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && result[MSB-1:FRAC_W] == '1 && result[FRAC_W-1:0] != '0) |-> (result == QNAN));

    // R11: a strobe in mid-operation does not disturb the sequence
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state == ST_ALIGN) |=> (state == ST_ADD));

endmodule

bind fpadd_seq fpadd_seq_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_valid(res_valid),
    .result(result), .overflow(overflow), .underflow(underflow), .state(state)
);

// File: tb/tb_fpadd_seq.sv
`timescale 1ns/1ps
module tb_fpadd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sub_sel = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        overflow;
    logic        underflow;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    fpadd_seq dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .result(result),
        .overflow(overflow), .underflow(underflow)
    );

    localparam logic [31:0] QNAN = 32'h7FC00000;

    // exact wide-integer sum rounded to nearest-even: {overflow, underflow, word}
    function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
        logic         sa, sb, s, g, stk, unf;
        logic [7:0]   xa, xb;
        logic [22:0]  fa, fb;
        logic [279:0] va, vb, mag;
        logic [24:0]  keep;
        int           p, sh, e;
        sa = a[31]; sb = b[31] ^ sub;
        xa = a[30:23]; xb = b[30:23];
        fa = a[22:0];  fb = b[22:0];
        if ((xa == 8'hFF && fa != 0) || (xb == 8'hFF && fb != 0)) return {2'b00, QNAN};
        if (xa == 8'hFF && xb == 8'hFF) return (sa != sb) ? {2'b00, QNAN} : {2'b00, sa, 8'hFF, 23'h0};
        if (xa == 8'hFF) return {2'b00, sa, 8'hFF, 23'h0};
        if (xb == 8'hFF) return {2'b00, sb, 8'hFF, 23'h0};
        va = '0; va[23:0] = {xa != 8'd0, fa};
        vb = '0; vb[23:0] = {xb != 8'd0, fb};
        va = va << ((xa == 8'd0) ? 0 : (int'(xa) - 1));
        vb = vb << ((xb == 8'd0) ? 0 : (int'(xb) - 1));
        if (sa == sb) begin
            mag = va + vb; s = sa;
        end else if (va >= vb) begin
            mag = va - vb; s = (mag == 0) ? 1'b0 : sa;
        end else begin
            mag = vb - va; s = sb;
        end
        p = -1;
        for (int i = 0; i < 280; i++) if (mag[i]) p = i;
        if (p <= 23) begin
            unf = (p >= 0 && p < 23);
            return {1'b0, unf, s, mag[30:0]};
        end
        sh   = p - 23;
        keep = 25'(mag >> sh);
        g    = mag[sh-1];
        stk  = 1'b0;
        for (int i = 0; i < sh - 1; i++) stk = stk | mag[i];
        if (g && (stk || keep[0])) keep = keep + 25'd1;
        if (keep[24]) begin
            keep = keep >> 1; sh = sh + 1;
        end
        e = sh + 1;
        if (e >= 255) return {2'b10, s, 8'hFF, 23'h0};
        return {2'b00, s, 8'(e), keep[22:0]};
    endfunction

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got ovf=%0b unf=%0b res=%08h, expected ovf=%0b unf=%0b res=%08h",
                     req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    // issues one request; optionally strobes a second request while busy
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic inject, output logic [33:0] got, output int lat);
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = s; in_valid = 1'b1;
        @(negedge clk);
        lat = 1;
        if (inject) begin
            op_a = 32'h40A00000; op_b = 32'h40A00000; sub_sel = 1'b0;
        end else begin
            in_valid = 1'b0;
        end
        while (!res_valid && lat < 40) begin
            @(negedge clk);
            lat++;
            if (lat == 3) in_valid = 1'b0;
        end
        in_valid = 1'b0;
        got = {overflow, underflow, result};
        if (!res_valid) begin
            checks++; errors++;
            $display("FAIL R10: no result strobe, got 0 expected 1");
        end
    endtask

    function automatic logic [31:0] rand_op();
        int          k;
        logic [31:0] w;
        k = int'($urandom_range(0, 9));
        w = $urandom();
        case (k)
            0: w[30:0] = '0;
            1: w[30:23] = 8'h00;
            2: w[30:23] = 8'(254 - int'($urandom_range(0, 2)));
            3: w[30:23] = 8'(int'($urandom_range(1, 3)));
            4: begin w[30:23] = 8'hFF; if (w[1]) w[22:0] = '0; end
            default: if (w[30:23] == 8'hFF) w[30] = 1'b0;
        endcase
        return w;
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [33:0] got;
        int          lat;
        void'($urandom(32'h5EED1234));

        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset outputs", {overflow, underflow, result}, 34'h0);
        check_int("R12 reset strobe", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 worked example, R10 latency
        run(32'h3F000000, 32'hBEE00000, 1'b0, 1'b0, got, lat);
        check("R2 0.5 + -0.4375", got, {2'b00, 32'h3D800000});
        check_int("R10 finite latency", lat, 5);
        @(negedge clk);
        check_int("R10 strobe is one cycle", int'(res_valid), 0);

        // R2 tie to even
        run(32'h3F800000, 32'h33800000, 1'b0, 1'b0, got, lat);
        check("R2 tie rounds to even", got, {2'b00, 32'h3F800000});

        // R3 subtraction
        run(32'h40A00000, 32'h3F000000, 1'b1, 1'b0, got, lat);
        check("R3 5.0 - 0.5", got, {2'b00, 32'h40900000});

        // R8 zeros
        run(32'h3F800000, 32'h3F800000, 1'b1, 1'b0, got, lat);
        check("R8 exact cancel gives +0", got, 34'h0);
        run(32'h80000000, 32'h80000000, 1'b0, 1'b0, got, lat);
        check("R8 -0 + -0", got, {2'b00, 32'h80000000});

        // R4 NaN cases
        run(32'h7F800001, 32'h3F800000, 1'b0, 1'b0, got, lat);
        check("R4 NaN operand", got, {2'b00, QNAN});
        check_int("R10 special latency", lat, 2);
        run(32'h7F800000, 32'hFF800000, 1'b0, 1'b0, got, lat);
        check("R4 inf + -inf", got, {2'b00, QNAN});
        run(32'h7F800000, 32'h7F800000, 1'b1, 1'b0, got, lat);
        check("R4 inf - inf", got, {2'b00, QNAN});

        // R5 infinity with finite
        run(32'hFF800000, 32'h3F800000, 1'b0, 1'b0, got, lat);
        check("R5 -inf + 1", got, {2'b00, 32'hFF800000});
        run(32'h3F800000, 32'h7F800000, 1'b1, 1'b0, got, lat);
        check("R5 1 - inf", got, {2'b00, 32'hFF800000});

        // R6 overflow
        run(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 1'b0, got, lat);
        check("R6 positive overflow", got, {2'b10, 32'h7F800000});
        run(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 1'b0, got, lat);
        check("R6 negative overflow", got, {2'b10, 32'hFF800000});

        // R7 and R1 denormals
        run(32'h00800000, 32'h00000001, 1'b1, 1'b0, got, lat);
        check("R7 underflow to denormal", got, {2'b01, 32'h007FFFFF});
        run(32'h00000003, 32'h00000005, 1'b0, 1'b0, got, lat);
        check("R1 denormal sum", got, {2'b01, 32'h00000008});
        run(32'h007FFFFF, 32'h00000001, 1'b0, 1'b0, got, lat);
        check("R1 denormal carries into normal", got, {2'b00, 32'h00800000});

        // R9 rounding carry
        run(32'h3FFFFFFF, 32'h33800000, 1'b0, 1'b0, got, lat);
        check("R9 rounding carry renormalizes", got, {2'b00, 32'h40000000});
        check_int("R9 R10 carry latency", lat, 7);

        // R11 strobe while busy is ignored
        run(32'h3F000000, 32'hBEE00000, 1'b0, 1'b1, got, lat);
        check("R11 pending result unchanged", got, {2'b00, 32'h3D800000});
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (res_valid) extra++;
            end
            check_int("R11 no result from ignored strobe", extra, 0);
        end

        // random sweep against the reference, R2 R3 R4 R5 R6 R7 R8
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] ra, rb;
            logic        rs;
            ra = rand_op();
            rb = rand_op();
            rs = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 4) == 0) begin
                rb = ra ^ {24'h0, 8'($urandom_range(0, 255))};
                rs = ~rb[31] ^ ra[31] ^ 1'b1;
                rs = 1'b1;
                rb[31] = ra[31];
            end
            run(ra, rb, rs, 1'b0, got, lat);
            check("R2 R3 random vs reference", got, ref_add(ra, rb, rs));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule